// File: doc/BRIEF.md
# Burst Synchronous Serial Port

This block is a clocked synchronous serial channel that exchanges 8-bit bytes between an 8-entry FIFO and four serial pins. The host fills the FIFO through a simple write strobe, programs a burst length of 1 to 8 bytes and issues one start pulse. The port then shifts the whole burst with no host help between bytes. Each byte sent is taken from the FIFO head, and each byte received is appended at the tail. When the burst ends, the FIFO holds the received bytes in the order they arrived.

The port is either a clock master, making the serial clock from the system clock with a programmable half period, or a slave that follows an external clock. The external clock passes through a synchronizer first. An optional chip-select mode ties both output enables to an active-low select input. Raising the select in the middle of a burst aborts the burst and flags an error.

Top module: `sync_serial_burst`

## Requirements
- R1: The FIFO stores up to 8 bytes. While idle, `wr_valid` appends `wr_data`, a write to a full FIFO is dropped, `rd_pop` removes the head, `rd_data` shows the head (0x00 when empty) and `fifo_level` gives the occupancy.
- R2: A `start` pulse while idle raises `busy` on the next cycle and runs a burst of `cfg_len`+1 bytes. While busy, `start`, `wr_valid` and `rd_pop` have no effect.
- R3: Each transmitted byte is taken from the FIFO head and each received byte is appended at the tail, so after an n-byte burst started with n bytes queued, the FIFO holds the n received bytes in arrival order.
- R4: Bytes are shifted most significant bit first. `sdo_o` changes only on a falling serial clock edge, and `sdi_i` is captured on the rising edge.
- R5: In master mode `sck_o` idles high and each phase lasts `cfg_half` system clocks. The first falling edge comes exactly `cfg_half` cycles after the start cycle, and successive falling edges, within and across bytes, are 2×`cfg_half` cycles apart.
- R6: In slave mode (`cfg_master`=0) `sck_oe` stays low and the port shifts on edges of `sck_i`, seen through a two-flop synchronizer.
- R7: After the eighth rising edge of the last byte, `busy` drops and `done` rises. `done` and `err` are cleared by the next accepted start.
- R8: With `cfg_cs_mode`=0, `sdo_oe` is 1. With `cfg_cs_mode`=1, `sdo_oe` (and `sck_oe` in master mode) is high only while the synchronized `cs_n_i` is low. A high select releases both outputs to high impedance and stops the master clock.
- R9: In chip-select mode, a rising `cs_n_i` while busy ends the burst: `busy` clears, `err` sets, `done` stays low. A rising select while idle sets no error.
- R10: After reset, `busy`, `done`, `err` and `fifo_level` are 0 and `sck_o` and `sdo_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = drive serial clock, 0 = follow `sck_i` |
| cfg_cs_mode | input | 1 | 1 = outputs gated by chip select, abort on deselect |
| cfg_half | input | HALF_W (8) | Master clock phase length in system clocks (0 treated as 1) |
| cfg_len | input | 3 | Burst length minus one |
| wr_valid | input | 1 | Append `wr_data` to the FIFO (idle only) |
| wr_data | input | 8 | Byte to append |
| rd_pop | input | 1 | Remove the FIFO head (idle only) |
| rd_data | output | 8 | FIFO head, 0x00 when empty |
| fifo_level | output | 4 | Bytes held in the FIFO |
| start | input | 1 | Begin a burst |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Last burst completed |
| err | output | 1 | Last burst aborted by deselect |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data out enable |
| sdi_i | input | 1 | Serial data in |
| cs_n_i | input | 1 | Active-low chip select |

## Verification
Host-side results are due one cycle after the driving edge. `busy` is high after the start edge, and a FIFO write or pop shows on `fifo_level` one edge later, so the bench samples at the next falling clock edge. Master timing is counted exactly: `sck_o` must still be high after `cfg_half`−1 edges following the start edge and low after `cfg_half`. The spacing between its falling edges is measured in cycles. Pin inputs (`sck_i`, `cs_n_i`, `sdi_i`) need two synchronizer edges plus one engine edge, so the bench holds each slave clock phase for eight cycles and waits four or more cycles after moving the select before it checks enables, `busy`, `err` or the data bit.

// File: rtl/ssp_pkg.sv
// Shared types for the burst synchronous serial port.
package ssp_pkg;
    // One-cycle serial clock edge events handed from the clock unit to the engine.
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edge_t;

    localparam int SSP_SYNC_STAGES = 2;
endpackage

// File: rtl/ssp_sync.sv
// Multi-bit flop-chain synchronizer for asynchronous pin inputs.
// Assumes each bit is independent (no bus coherence is needed).
module ssp_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // Shift each stage one step down the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else if (i == 0) stg[i] <= d;
            else stg[i] <= stg[(i == 0) ? 0 : i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ssp_fifo.sv
// Byte FIFO with simultaneous push/pop. A push into a full FIFO is dropped
// unless a pop happens in the same cycle. Head reads 0 when empty.
// Assumes DEPTH is a power of two.
module ssp_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [LVL_W-1:0]  level
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic full, empty, do_push, do_pop;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_pop  = pop & ~empty;
    assign do_push = push & (~full | do_pop);
    assign head    = empty ? '0 : mem[rptr];

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
    p_full_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> level == LVL_W'(DEPTH));
endmodule

// File: rtl/ssp_clkgen.sv
// Serial clock unit. Master: toggles an internal clock every HALF cycles
// while run is high, idling high otherwise. Slave: detects edges of the
// synchronized external clock. Emits single-cycle rise/fall events.
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    input  logic              sck_sync,
    output logic              sck_int,
    output sck_edge_t         ev
);
    logic [HALF_W-1:0] cnt, half_eff;
    logic tick, sck_d;

    assign half_eff = (half == '0) ? HALF_W'(1) : half;
    assign tick     = master & run & (cnt == half_eff - 1'b1);

    // Phase counter and master clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !master) begin
            cnt     <= '0;
            sck_int <= 1'b1;
        end else if (tick) begin
            cnt     <= '0;
            sck_int <= ~sck_int;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Delay of the synchronized external clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b1;
        else        sck_d <= sck_sync;
    end

    // Select the event source for the active mode.
    always_comb begin
        if (master) begin
            ev.fall = tick & sck_int;
            ev.rise = tick & ~sck_int;
        end else begin
            ev.fall = sck_d & ~sck_sync;
            ev.rise = ~sck_d & sck_sync;
        end
    end

    p_single_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev.rise && ev.fall));
    p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> sck_int);
endmodule

// File: rtl/sync_serial_burst.sv
// Burst synchronous serial port: full-duplex MSB-first byte shifting between
// an 8-deep FIFO and serial pins, 1..DEPTH bytes per start command.
// Assumes pin inputs are asynchronous (synchronized here) and that the host
// touches the FIFO only while idle.
module sync_serial_burst
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH = 8,
    parameter int HALF_W = 8,
    localparam int LEN_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_cs_mode,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [LVL_W-1:0]  fifo_level,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              err,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              sdo_o,
    output logic              sdo_oe,
    input  logic              sdi_i,
    input  logic              cs_n_i
);
    logic cs_s, sck_s, sdi_s, cs_d;
    logic cs_ok, cs_rise, abort, byte_end, last_byte;
    logic eng_pop, f_push, f_pop, sck_int;
    logic [DATA_W-1:0] tx_sr, rx_sr, rx_next, f_wdata;
    logic [BIT_W-1:0] bit_cnt;
    logic [LVL_W-1:0] left;
    sck_edge_t ev;

    ssp_sync #(.W(3), .STAGES(SSP_SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n_i, sck_i, sdi_i}),
        .q({cs_s, sck_s, sdi_s})
    );

    // Delayed select for deselect-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_d <= 1'b1;
        else        cs_d <= cs_s;
    end

    assign cs_ok     = ~cfg_cs_mode | ~cs_s;
    assign cs_rise   = cs_s & ~cs_d;
    assign abort     = busy & cfg_cs_mode & cs_rise;
    assign byte_end  = busy & ~abort & ev.rise & (bit_cnt == BIT_W'(DATA_W - 1));
    assign last_byte = (left == LVL_W'(1));
    assign rx_next   = {rx_sr[DATA_W-2:0], sdi_s};
    assign eng_pop   = (~busy & start) | (byte_end & ~last_byte);
    assign f_push    = byte_end | (~busy & wr_valid);
    assign f_wdata   = busy ? rx_next : wr_data;
    assign f_pop     = eng_pop | (~busy & ~start & rd_pop);

    ssp_clkgen #(.HALF_W(HALF_W)) u_clk (
        .clk(clk), .rst_n(rst_n),
        .master(cfg_master), .run(busy & cs_ok), .half(cfg_half),
        .sck_sync(sck_s), .sck_int(sck_int), .ev(ev)
    );

    ssp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(f_push), .push_data(f_wdata), .pop(f_pop),
        .head(rd_data), .level(fifo_level)
    );

    // Burst engine: start, shift per edge, byte hand-off, completion, abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
            sdo_o   <= 1'b1;
            tx_sr   <= '0;
            rx_sr   <= '0;
            bit_cnt <= '0;
            left    <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                done    <= 1'b0;
                err     <= 1'b0;
                tx_sr   <= rd_data;
                bit_cnt <= '0;
                left    <= LVL_W'(cfg_len) + LVL_W'(1);
            end
        end else if (abort) begin
            busy <= 1'b0;
            err  <= 1'b1;
        end else begin
            if (ev.fall) begin
                sdo_o <= tx_sr[DATA_W-1];
                tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            end
            if (ev.rise) begin
                rx_sr   <= rx_next;
                bit_cnt <= bit_cnt + 1'b1;
                if (byte_end) begin
                    left <= left - 1'b1;
                    if (last_byte) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        tx_sr <= rd_data;
                    end
                end
            end
        end
    end

    // Pin drivers and enables.
    assign sck_o  = cfg_master ? sck_int : 1'b1;
    assign sck_oe = cfg_master & cs_ok;
    assign sdo_oe = cs_ok;

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy);
    p_busy_not_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    p_sdo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ev.fall |=> $stable(sdo_o));
    p_slave_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> !sck_oe);
    p_deselect_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cs_mode && cs_s |-> !sdo_oe && !sck_oe);
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cfg_cs_mode && cs_rise |=> !busy && err && !done);
endmodule

// File: tb/sync_serial_burst_test.sv
`timescale 1ns/1ps
module sync_serial_burst_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_master = 1'b1, cfg_cs_mode = 1'b0;
    logic [7:0] cfg_half = 8'd4;
    logic [2:0] cfg_len = 3'd0;
    logic wr_valid = 1'b0, rd_pop = 1'b0, start = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [3:0] fifo_level;
    logic busy, done, err;
    logic sck_i = 1'b1, sck_o, sck_oe, sdo_o, sdo_oe;
    logic sdi_drv = 1'b0, loop = 1'b0, cs_n = 1'b1;
    logic sdi_i;
    int tests = 0, fails = 0;

    assign sdi_i = loop ? sdo_o : sdi_drv;

    always #2 clk = ~clk;

    sync_serial_burst uut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cs_mode(cfg_cs_mode),
        .cfg_half(cfg_half), .cfg_len(cfg_len), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_pop(rd_pop), .rd_data(rd_data), .fifo_level(fifo_level), .start(start),
        .busy(busy), .done(done), .err(err), .sck_i(sck_i), .sck_o(sck_o),
        .sck_oe(sck_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .sdi_i(sdi_i), .cs_n_i(cs_n)
    );

    // Master-clock monitor: captures sdo at sck_o rises, measures fall spacing.
    logic mon_en = 1'b0, prev_sck = 1'b1;
    logic [31:0] cap = '0;
    int cyc = 0, last_fall = -1, min_sp = 1000, max_sp = 0;
    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            if (!prev_sck && sck_o) cap = {cap[30:0], sdo_o};
            if (prev_sck && !sck_o) begin
                if (last_fall >= 0) begin
                    if (cyc - last_fall < min_sp) min_sp = cyc - last_fall;
                    if (cyc - last_fall > max_sp) max_sp = cyc - last_fall;
                end
                last_fall = cyc;
            end
        end
        prev_sck = sck_o;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push_byte(input logic [7:0] b);
        wr_valid = 1'b1; wr_data = b; @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [7:0] exp);
        chk(req, rd_data, exp);
        rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
    endtask

    task automatic flush();
        for (int i = 0; i < 10; i++) if (fifo_level != 0) begin
            rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
        end
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 4000) begin @(negedge clk); n++; end
        chk(req, busy, 1'b0);
    endtask

    // R10: state after reset.
    task automatic t_reset();
        chk("R10 busy", busy, 0); chk("R10 done", done, 0); chk("R10 err", err, 0);
        chk("R10 level", fifo_level, 0); chk("R10 sck_o", sck_o, 1); chk("R10 sdo_o", sdo_o, 1);
    endtask

    // R1: fill past capacity, drain in order, empty head reads zero.
    task automatic t_fifo();
        for (int i = 0; i < 9; i++) push_byte(8'(8'h10 + i));
        chk("R1 level full", fifo_level, 8);
        for (int i = 0; i < 8; i++) pop_expect("R1 order", 8'(8'h10 + i));
        chk("R1 level empty", fifo_level, 0);
        chk("R1 empty head", rd_data, 8'h00);
    endtask

    // R2/R3/R4/R5/R7: 4-byte master loopback burst.
    task automatic t_master_burst();
        cfg_master = 1; cfg_cs_mode = 0; cfg_half = 4; cfg_len = 3; loop = 1;
        push_byte(8'hA5); push_byte(8'h3C); push_byte(8'hF0); push_byte(8'h81);
        cap = '0; last_fall = -1; min_sp = 1000; max_sp = 0; mon_en = 1;
        pulse_start();
        chk("R2 busy after start", busy, 1);
        chk("R7 err cleared by start", err, 0);
        cycles(3);
        chk("R5 sck high before half", sck_o, 1);
        cycles(1);
        chk("R5 first fall at half", sck_o, 0);
        chk("R5 sck_oe master", sck_oe, 1);
        wait_idle("R7 busy low at end");
        cycles(2);
        mon_en = 0;
        chk("R7 done", done, 1);
        chk("R4 msb-first stream", cap, 32'hA53CF081);
        chk("R5 min fall spacing", min_sp, 8);
        chk("R5 max fall spacing", max_sp, 8);
        chk("R3 level after burst", fifo_level, 4);
        pop_expect("R3 rx0", 8'hA5); pop_expect("R3 rx1", 8'h3C);
        pop_expect("R3 rx2", 8'hF0); pop_expect("R3 rx3", 8'h81);
        loop = 0;
    endtask

    // R2: start, write and pop during a burst have no effect.
    task automatic t_ignore_busy();
        cfg_master = 1; cfg_cs_mode = 0; cfg_half = 4; cfg_len = 0; loop = 1;
        push_byte(8'h5A);
        pulse_start();
        cycles(5);
        start = 1; wr_valid = 1; wr_data = 8'h11; rd_pop = 1;
        @(negedge clk);
        start = 0; wr_valid = 0; rd_pop = 0;
        wait_idle("R2 single byte ends");
        cycles(2);
        chk("R2 busy stays low", busy, 0);
        chk("R2 level unchanged by busy writes", fifo_level, 1);
        pop_expect("R2 data intact", 8'h5A);
        loop = 0;
    endtask

    // R4/R6/R3: slave mode, bench drives sck_i and sdi_i.
    task automatic t_slave();
        logic [15:0] rx_bits = 16'h2DE1;
        logic [15:0] got = '0;
        cfg_master = 0; cfg_cs_mode = 0; cfg_len = 1;
        push_byte(8'h96); push_byte(8'h4B);
        pulse_start();
        chk("R6 slave sck_oe low", sck_oe, 0);
        cycles(8);
        chk("R6 waits for external clock", busy, 1);
        for (int b = 15; b >= 0; b--) begin
            sck_i = 0; sdi_drv = rx_bits[b];
            cycles(8);
            got = {got[14:0], sdo_o};
            sck_i = 1;
            cycles(8);
        end
        chk("R4 slave tx msb-first", got, 16'h964B);
        chk("R6 slave done", done, 1);
        chk("R6 slave idle", busy, 0);
        pop_expect("R3 slave rx0", 8'h2D); pop_expect("R3 slave rx1", 8'hE1);
    endtask

    // R8: chip-select gating of output enables.
    task automatic t_cs_gate();
        cfg_master = 1; cfg_cs_mode = 0; cs_n = 1;
        cycles(4);
        chk("R8 sdo_oe without cs mode", sdo_oe, 1);
        cfg_cs_mode = 1;
        cycles(1);
        chk("R8 sdo float deselected", sdo_oe, 0);
        chk("R8 sck float deselected", sck_oe, 0);
        cs_n = 0; cycles(4);
        chk("R8 sdo enabled selected", sdo_oe, 1);
        chk("R8 sck enabled selected", sck_oe, 1);
        cs_n = 1; cycles(4);
        chk("R8 sdo float after deselect", sdo_oe, 0);
        chk("R9 idle deselect no err", err, 0);
    endtask

    // R9: deselect mid-byte aborts the burst.
    task automatic t_abort();
        cfg_master = 1; cfg_cs_mode = 1; cfg_half = 4; cfg_len = 1; loop = 1;
        cs_n = 0; cycles(4);
        push_byte(8'hC3); push_byte(8'h3C);
        pulse_start();
        cycles(20);
        chk("R9 busy mid byte", busy, 1);
        cs_n = 1; cycles(5);
        chk("R9 busy cleared", busy, 0);
        chk("R9 err set", err, 1);
        chk("R9 done low", done, 0);
        chk("R8 sck idle high after abort", sck_o, 1);
        flush();
        loop = 0; cfg_cs_mode = 0;
        cycles(4);
    endtask

    initial begin
        #600000;
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cycles(4);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fifo();
        t_cs_gate();
        t_abort();
        t_master_burst();
        t_ignore_busy();
        t_slave();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule